// File: doc/BRIEF.md
# Tuning-Slope Calibration Sequencer

This block runs once after power-up to learn how a voltage-controlled reference oscillator answers its control word. It drives an unsigned control word to the oscillator and asks an external frequency counter for one run per trial. At the end of each run the counter returns a signed frequency error in 0.25 Hz units, so one unit stands for 0.25 Hz. The block first tries the top and then the bottom of the legal control range. The first trial is held in an endpoint register called side A and the second in side B. From this pair it works out the sensitivity.

The block then brackets the zero-error control point. Each new trial is placed where the interpolation line through the two endpoints predicts that the larger of the two errors would be cut in half. The new result replaces that larger endpoint. The loop ends when both endpoint errors are within one unit. The block then reports a nominal control word and the sensitivity, so that they can be stored and reused later. It watches each run and tells the counter to cut the run short when the accumulated phase deviation grows too large or the run lasts too many seconds. All divisions share one multi-cycle signed divider.

The control flow is a state machine:
- `ST_IDLE`, `ST_DONE` and `ST_FAIL` go to `ST_APPLY` on start.
- `ST_APPLY` (the trial word is applied and the run-start pulse is given) goes to `ST_RUN`.
- `ST_RUN` goes to `ST_EVAL` when a result arrives, or to `ST_STOPW` when the run guard trips.
- `ST_STOPW` goes to `ST_EVAL` when the result arrives.
- `ST_EVAL` goes to `ST_APPLY` after the top extreme, to `ST_DSENS` after the bottom extreme, and to `ST_CHECK` after any later trial.
- `ST_DSENS` goes to `ST_WSENS`, or to `ST_FAIL` when the two extremes give equal errors.
- `ST_WSENS` goes to `ST_CHECK`.
- `ST_CHECK` goes to `ST_DNOM` or straight to `ST_DONE` when the errors have converged. It goes to `ST_FAIL` when the trial cap is reached or the two errors are equal. Otherwise it goes to `ST_DSTEP`.
- `ST_DSTEP` goes to `ST_WSTEP`, which goes back to `ST_APPLY`.
- `ST_DNOM` goes to `ST_WNOM`, which goes to `ST_DONE`.

Top module: `calib_seq`

## Requirements
- R1: After start, the first trial applies control word CMAX and the second applies CMIN. Each trial is announced by a one-cycle `meas_start_o` pulse, with `ctrl_o` already holding the trial word in that cycle. The CMAX result goes into side A and the CMIN result into side B.
- R2: The reported sensitivity `sens_o` is trunc((CMAX-CMIN)*2^FRAC / (eA-eB)), taken from the two extreme errors, with division truncating toward zero. If the two extreme errors are equal, the block ends in fail.
- R3: A trial after the extremes uses control word clamp(cL - trunc(eL*(cL-cS) / (2*(eL-eS)))). L is the endpoint with the larger |error|; on a tie L is side A. S is the other endpoint. clamp limits the value to [CMIN, CMAX].
- R4: The result of a trial after the extremes replaces endpoint L, chosen as in R3 from the endpoints before that result. `ctrl_o` holds steady from the run-start pulse until the next trial.
- R5: When |eA|<=1 and |eB|<=1, the block ends in done with `nom_o` = clamp(cA - trunc(eA*(cA-cB)/(eA-eB))). If eA equals eB, `nom_o` is instead floor((cA+cB)/2).
- R6: Positive and negative tuning slopes are both handled by the same rules.
- R7: While a run is open and no result arrives, `meas_stop_o` pulses for one cycle when `dev_i` is greater than DEV_LIM or less than -DEV_LIM, or when RUN_SECS `tick_i` pulses have been counted in the run. `dev_i` equal to ±DEV_LIM does not stop the run. The result is accepted both before and after the stop.
- R8: If the errors have not converged after MAX_ITER trials past the extremes, or if the two endpoint errors are equal without having converged, the block ends in fail.
- R9: `done_o` and `fail_o` are never both high. Each holds until the next start. A start pulse while the block is busy has no effect on the trial sequence.
- R10: After reset, `ctrl_o` is CMIN, `busy_o`, `done_o`, `fail_o`, `meas_start_o` and `meas_stop_o` are low, and `sens_o` and `nom_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration (ignored while busy) |
| tick_i | input | 1 | One-second tick for the run-length guard |
| dev_i | input | DVW | Signed accumulated phase deviation of the open run |
| meas_valid_i | input | 1 | Frequency-error result is valid |
| meas_err_i | input | EW | Signed frequency error, 0.25 Hz units |
| ctrl_o | output | CW | Oscillator control word |
| meas_start_o | output | 1 | One-cycle pulse: begin a run at the current control word |
| meas_stop_o | output | 1 | One-cycle pulse: cut the open run short |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration converged, results valid |
| fail_o | output | 1 | Calibration failed |
| sens_o | output | CW+FRAC+2 | Signed sensitivity, control units per error unit, FRAC fraction bits |
| nom_o | output | CW | Nominal zero-error control word |

## Verification
The case hardest to reach is a sequence that does not converge and runs into the trial cap or into equal endpoint errors. The bench reaches it with an oscillator model whose zero point lies outside the control range, so that clamped trials keep landing on the same word. It also uses a model with zero slope. The two run-guard thresholds need a run that is held open on purpose. The bench holds runs open to step `dev_i` across the exact limit on both signs, and to deliver exactly RUN_SECS ticks before the result.

// File: rtl/calib_seq_pkg.sv
package calib_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_APPLY,
        ST_RUN,
        ST_STOPW,
        ST_EVAL,
        ST_DSENS,
        ST_WSENS,
        ST_CHECK,
        ST_DSTEP,
        ST_WSTEP,
        ST_DNOM,
        ST_WNOM,
        ST_DONE,
        ST_FAIL
    } cal_state_t;

    localparam logic [1:0] PH_TOP  = 2'd0;
    localparam logic [1:0] PH_BOT  = 2'd1;
    localparam logic [1:0] PH_ITER = 2'd2;

endpackage

// File: rtl/calib_sdiv.sv
// Signed restoring divider, one quotient bit per cycle, truncates toward zero.
module calib_sdiv #(
    parameter int W = 34
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                busy,
    output logic                done,
    output logic signed [W-1:0] quot
);
    localparam int CNW = $clog2(W + 1);

    logic [W-1:0]   rem_q, quo_q, dv_q;
    logic [CNW-1:0] cnt_q;
    logic           neg_q, run_q, done_q;
    logic [W-1:0]   quot_q;

    logic [W-1:0]   num_mag, den_mag;
    logic [W:0]     trial;
    logic [W-1:0]   rem_n, quo_n;

    always_comb begin
        num_mag = num[W-1] ? W'(-num) : W'(num);
        den_mag = den[W-1] ? W'(-den) : W'(den);
        trial   = {rem_q, quo_q[W-1]} - {1'b0, dv_q};
        if (!trial[W]) begin
            rem_n = trial[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_n = {rem_q[W-2:0], quo_q[W-1]};
            quo_n = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            neg_q  <= 1'b0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            quot_q <= '0;
        end else if (start && !run_q) begin
            rem_q  <= '0;
            quo_q  <= num_mag;
            dv_q   <= den_mag;
            neg_q  <= num[W-1] ^ den[W-1];
            cnt_q  <= CNW'(W);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNW'(1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
                quot_q <= neg_q ? (~quo_n + 1'b1) : quo_n;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy = run_q;
    assign done = done_q;
    assign quot = $signed(quot_q);
endmodule

// File: rtl/calib_run_guard.sv
// Flags a run that has drifted too far or lasted too long.
module calib_run_guard #(
    parameter int DVW      = 16,
    parameter int DEV_LIM  = 256,
    parameter int RUN_SECS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  active,
    input  logic                  tick,
    input  logic signed [DVW-1:0] dev,
    output logic                  hit
);
    localparam int TCW = $clog2(RUN_SECS + 1);
    localparam logic signed [DVW-1:0] LIM_P = DVW'(DEV_LIM);
    localparam logic signed [DVW-1:0] LIM_N = -LIM_P;
    localparam logic [TCW-1:0] SECS = TCW'(RUN_SECS);

    logic [TCW-1:0] secs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            secs_q <= '0;
        else if (clr)
            secs_q <= '0;
        else if (active && tick && (secs_q < SECS))
            secs_q <= secs_q + 1'b1;
    end

    assign hit = active && ((dev > LIM_P) || (dev < LIM_N) || (secs_q >= SECS));
endmodule

// File: rtl/calib_seq.sv
module calib_seq
    import calib_seq_pkg::*;
#(
    parameter int CW       = 12,
    parameter int EW       = 12,
    parameter int FRAC     = 8,
    parameter int DVW      = 16,
    parameter int DEV_LIM  = 256,
    parameter int RUN_SECS = 256,
    parameter int MAX_ITER = 32,
    parameter int CMIN     = 0,
    parameter int CMAX     = 4095
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     tick_i,
    input  logic signed [DVW-1:0]    dev_i,
    input  logic                     meas_valid_i,
    input  logic signed [EW-1:0]     meas_err_i,
    output logic [CW-1:0]            ctrl_o,
    output logic                     meas_start_o,
    output logic                     meas_stop_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     fail_o,
    output logic signed [CW+FRAC+1:0] sens_o,
    output logic [CW-1:0]            nom_o
);
    localparam int DW  = CW + EW + FRAC + 2;
    localparam int SW  = CW + FRAC + 2;
    localparam int ITW = $clog2(MAX_ITER + 1);
    localparam logic signed [DW-1:0] CMIN_X   = DW'(CMIN);
    localparam logic signed [DW-1:0] CMAX_X   = DW'(CMAX);
    localparam logic signed [DW-1:0] SENS_NUM = DW'((CMAX - CMIN) * (2 ** FRAC));
    localparam logic signed [DW-1:0] ONE_P    = DW'(1);
    localparam logic signed [DW-1:0] ONE_N    = -ONE_P;

    cal_state_t state_q, state_n;

    logic [CW-1:0]        ctrl_q, ca_q, cb_q, nom_q;
    logic signed [EW-1:0] ea_q, eb_q, m_q;
    logic [1:0]           phase_q;
    logic [ITW-1:0]       iter_q;
    logic signed [SW-1:0] sens_q;
    logic                 sel_a_q;

    logic signed [DW-1:0] ca_x, cb_x, ea_x, eb_x, mag_a, mag_b;
    logic signed [DW-1:0] cl_x, cs_x, el_x, es_x;
    logic signed [DW-1:0] dv_num, dv_den, dv_q;
    logic                 a_big, sel_l, conv, eq_err, cap_hit;
    logic                 dv_start, dv_busy, dv_done, guard_hit;
    logic [CW:0]          mid_sum;

    function automatic logic [CW-1:0] clampc(input logic signed [DW-1:0] v);
        if (v < CMIN_X)      return CW'(CMIN);
        else if (v > CMAX_X) return CW'(CMAX);
        else                 return v[CW-1:0];
    endfunction

    // ---------------- derived values ----------------
    always_comb begin
        ca_x    = DW'({1'b0, ca_q});
        cb_x    = DW'({1'b0, cb_q});
        ea_x    = DW'(ea_q);
        eb_x    = DW'(eb_q);
        mag_a   = ea_x[DW-1] ? -ea_x : ea_x;
        mag_b   = eb_x[DW-1] ? -eb_x : eb_x;
        a_big   = (mag_a >= mag_b);
        sel_l   = (state_q == ST_WSTEP) ? sel_a_q : a_big;
        cl_x    = sel_l ? ca_x : cb_x;
        cs_x    = sel_l ? cb_x : ca_x;
        el_x    = sel_l ? ea_x : eb_x;
        es_x    = sel_l ? eb_x : ea_x;
        conv    = (ea_x >= ONE_N) && (ea_x <= ONE_P) && (eb_x >= ONE_N) && (eb_x <= ONE_P);
        eq_err  = (ea_q == eb_q);
        cap_hit = (iter_q >= ITW'(MAX_ITER));
        mid_sum = {1'b0, ca_q} + {1'b0, cb_q};
    end

    // ---------------- shared divider ----------------
    always_comb begin
        dv_num   = '0;
        dv_den   = ONE_P;
        dv_start = 1'b0;
        case (state_q)
            ST_DSENS: begin
                dv_num   = SENS_NUM;
                dv_den   = ea_x - eb_x;
                dv_start = !eq_err && !dv_busy;
            end
            ST_DSTEP: begin
                dv_num   = el_x * (cl_x - cs_x);
                dv_den   = (el_x - es_x) <<< 1;
                dv_start = !dv_busy;
            end
            ST_DNOM: begin
                dv_num   = ea_x * (ca_x - cb_x);
                dv_den   = ea_x - eb_x;
                dv_start = !dv_busy;
            end
            default: ;
        endcase
    end

    calib_sdiv #(.W(DW)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .busy  (dv_busy),
        .done  (dv_done),
        .quot  (dv_q)
    );

    calib_run_guard #(.DVW(DVW), .DEV_LIM(DEV_LIM), .RUN_SECS(RUN_SECS)) guard_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_APPLY),
        .active (state_q == ST_RUN),
        .tick   (tick_i),
        .dev    (dev_i),
        .hit    (guard_hit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL:
                if (start_i) state_n = ST_APPLY;
            ST_APPLY: state_n = ST_RUN;
            ST_RUN:
                if (meas_valid_i)   state_n = ST_EVAL;
                else if (guard_hit) state_n = ST_STOPW;
            ST_STOPW:
                if (meas_valid_i) state_n = ST_EVAL;
            ST_EVAL:
                if (phase_q == PH_TOP)      state_n = ST_APPLY;
                else if (phase_q == PH_BOT) state_n = ST_DSENS;
                else                        state_n = ST_CHECK;
            ST_DSENS:
                if (eq_err)        state_n = ST_FAIL;
                else if (!dv_busy) state_n = ST_WSENS;
            ST_WSENS:
                if (dv_done) state_n = ST_CHECK;
            ST_CHECK:
                if (conv)         state_n = eq_err ? ST_DONE : ST_DNOM;
                else if (cap_hit) state_n = ST_FAIL;
                else if (eq_err)  state_n = ST_FAIL;
                else              state_n = ST_DSTEP;
            ST_DSTEP:
                if (!dv_busy) state_n = ST_WSTEP;
            ST_WSTEP:
                if (dv_done) state_n = ST_APPLY;
            ST_DNOM:
                if (!dv_busy) state_n = ST_WNOM;
            ST_WNOM:
                if (dv_done) state_n = ST_DONE;
            default: state_n = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CW'(CMIN);
            ca_q    <= '0;
            cb_q    <= '0;
            ea_q    <= '0;
            eb_q    <= '0;
            m_q     <= '0;
            phase_q <= PH_TOP;
            iter_q  <= '0;
            sens_q  <= '0;
            nom_q   <= '0;
            sel_a_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL:
                    if (start_i) begin
                        ctrl_q  <= CW'(CMAX);
                        phase_q <= PH_TOP;
                        iter_q  <= '0;
                        sens_q  <= '0;
                        nom_q   <= '0;
                    end
                ST_RUN, ST_STOPW:
                    if (meas_valid_i) m_q <= meas_err_i;
                ST_EVAL:
                    if (phase_q == PH_TOP) begin
                        ca_q    <= ctrl_q;
                        ea_q    <= m_q;
                        ctrl_q  <= CW'(CMIN);
                        phase_q <= PH_BOT;
                    end else if (phase_q == PH_BOT) begin
                        cb_q    <= ctrl_q;
                        eb_q    <= m_q;
                        phase_q <= PH_ITER;
                    end else begin
                        if (a_big) begin
                            ca_q <= ctrl_q;
                            ea_q <= m_q;
                        end else begin
                            cb_q <= ctrl_q;
                            eb_q <= m_q;
                        end
                        iter_q <= iter_q + 1'b1;
                    end
                ST_WSENS:
                    if (dv_done) sens_q <= dv_q[SW-1:0];
                ST_CHECK:
                    if (conv && eq_err) nom_q <= mid_sum[CW:1];
                ST_DSTEP:
                    sel_a_q <= a_big;
                ST_WSTEP:
                    if (dv_done) ctrl_q <= clampc(cl_x - dv_q);
                ST_WNOM:
                    if (dv_done) nom_q <= clampc(ca_x - dv_q);
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ctrl_o       = ctrl_q;
        meas_start_o = (state_q == ST_APPLY);
        meas_stop_o  = (state_q == ST_RUN) && guard_hit && !meas_valid_i;
        busy_o       = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
        done_o       = (state_q == ST_DONE);
        fail_o       = (state_q == ST_FAIL);
        sens_o       = sens_q;
        nom_o        = nom_q;
    end
endmodule

// File: rtl/calib_seq_chk.sv
module calib_seq_chk #(
    parameter int CW   = 12,
    parameter int CMIN = 0,
    parameter int CMAX = 4095
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [CW-1:0] ctrl_o,
    input logic          meas_start_o,
    input logic          meas_stop_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o
);
    p_first_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (meas_start_o && (int'(ctrl_o) == CMAX)));

    p_ctrl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |-> ((int'(ctrl_o) >= CMIN) && (int'(ctrl_o) <= CMAX)));

    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |=> $stable(ctrl_o));

    p_stop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stop_o |=> !meas_stop_o);

    p_stop_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stop_o |-> (busy_o && !meas_start_o));

    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);
endmodule

bind calib_seq calib_seq_chk #(.CW(CW), .CMIN(CMIN), .CMAX(CMAX)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ctrl_o       (ctrl_o),
    .meas_start_o (meas_start_o),
    .meas_stop_o  (meas_stop_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/calib_seq_tb_top.sv
`timescale 1ns/1ps
module calib_seq_tb_top;
    localparam int CW = 12, EW = 12, FRAC = 8, DVW = 16;
    localparam int DEV_LIM = 256, RUN_SECS = 256, MAX_ITER = 32;
    localparam int CMIN = 0, CMAX = 4095;
    localparam int SW = CW + FRAC + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, tick_i = 1'b0, meas_valid_i = 1'b0;
    logic signed [DVW-1:0] dev_i = '0;
    logic signed [EW-1:0]  meas_err_i = '0;
    logic [CW-1:0] ctrl_o, nom_o;
    logic meas_start_o, meas_stop_o, busy_o, done_o, fail_o;
    logic signed [SW-1:0] sens_o;

    always #5 clk = ~clk;

    calib_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i), .dev_i(dev_i),
        .meas_valid_i(meas_valid_i), .meas_err_i(meas_err_i), .ctrl_o(ctrl_o),
        .meas_start_o(meas_start_o), .meas_stop_o(meas_stop_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .sens_o(sens_o), .nom_o(nom_o)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // oscillator model and expected-value model
    longint pg, pc0;
    longint gca, gea, gcb, geb, gctrl, gsens, gnom;
    int gphase, giter, gfin;

    function automatic longint plant(input longint c);
        return (pg * (c - pc0)) / 64;
    endfunction

    function automatic longint lab(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint clampc(input longint v);
        if (v < CMIN) return CMIN;
        if (v > CMAX) return CMAX;
        return v;
    endfunction

    task automatic g_reset();
        gctrl = CMAX; gphase = 0; giter = 0; gfin = 0; gsens = 0; gnom = 0;
    endtask

    task automatic g_meas(input longint m);
        longint cl, el, cs, es;
        if (gphase == 0) begin
            gca = gctrl; gea = m; gctrl = CMIN; gphase = 1;
            return;
        end
        if (gphase == 1) begin
            gcb = gctrl; geb = m; gphase = 2;
            if (gea == geb) begin gfin = 2; return; end
            gsens = (longint'(CMAX - CMIN) * (64'sd1 <<< FRAC)) / (gea - geb);
        end else begin
            if (lab(gea) >= lab(geb)) begin gca = gctrl; gea = m; end
            else begin gcb = gctrl; geb = m; end
            giter++;
        end
        if (lab(gea) <= 1 && lab(geb) <= 1) begin
            gfin = 1;
            if (gea == geb) gnom = (gca + gcb) / 2;
            else gnom = clampc(gca - (gea * (gca - gcb)) / (gea - geb));
            return;
        end
        if (giter >= MAX_ITER || gea == geb) begin gfin = 2; return; end
        if (lab(gea) >= lab(geb)) begin cl = gca; el = gea; cs = gcb; es = geb; end
        else begin cl = gcb; el = geb; cs = gca; es = gea; end
        gctrl = clampc(cl - (el * (cl - cs)) / (2 * (el - es)));
    endtask

    // entered at the negedge where meas_start_o is high
    task automatic deliver(input longint err, input int dly, input int mode, input bit poke);
        @(negedge clk);                       // now in the run
        if (poke) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o && !meas_start_o, "R9 start while busy ignored", meas_start_o, 0);
        end
        for (int i = 0; i < dly; i++) @(negedge clk);
        if (mode == 1 || mode == 2) begin
            dev_i = (mode == 1) ? DVW'(DEV_LIM) : -DVW'(DEV_LIM);
            #1 chk(meas_stop_o == 1'b0, "R7 deviation at limit no stop", meas_stop_o, 0);
            @(negedge clk);
            dev_i = (mode == 1) ? DVW'(DEV_LIM + 1) : -DVW'(DEV_LIM + 1);
            #1 chk(meas_stop_o == 1'b1, "R7 deviation beyond limit stops", meas_stop_o, 1);
            @(negedge clk);
            dev_i = '0;
            #1 chk(meas_stop_o == 1'b0, "R7 stop is one pulse", meas_stop_o, 0);
        end else if (mode == 3) begin
            bit early;
            early = 1'b0;
            tick_i = 1'b1;
            for (int i = 0; i < RUN_SECS - 1; i++) begin
                @(negedge clk);
                if (meas_stop_o) early = 1'b1;
            end
            chk(!early, "R7 no stop before tick limit", early, 0);
            @(negedge clk);
            tick_i = 1'b0;
            #1 chk(meas_stop_o == 1'b1, "R7 stop at tick limit", meas_stop_o, 1);
            @(negedge clk);
        end
        meas_valid_i = 1'b1;
        meas_err_i = EW'(err);
        @(negedge clk);
        meas_valid_i = 1'b0;
    endtask

    task automatic run_cal(input longint g, input longint c0, input int dly,
                           input int mode, input bit poke, input string tag);
        int guard, trial;
        longint err;
        pg = g; pc0 = c0;
        g_reset();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0; trial = 0;
        while (!(done_o || fail_o) && guard < 20000) begin
            if (meas_start_o) begin
                if (trial < 2)
                    chk(longint'(ctrl_o) == gctrl, {"R1 extreme trial ", tag}, ctrl_o, gctrl);
                else
                    chk(longint'(ctrl_o) == gctrl, {"R3 R4 R6 bisect trial ", tag}, ctrl_o, gctrl);
                err = plant(ctrl_o);
                deliver(err, dly, (trial == 1) ? mode : 0, poke && trial == 2);
                g_meas(err);
                trial++;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        chk(done_o == (gfin == 1), {"R5 done flag ", tag}, done_o, gfin == 1);
        chk(fail_o == (gfin == 2), {"R8 fail flag ", tag}, fail_o, gfin == 2);
        if (gfin == 1) begin
            chk(longint'(sens_o) == gsens, {"R2 sensitivity ", tag}, sens_o, gsens);
            chk(longint'(nom_o) == gnom, {"R5 nominal ", tag}, nom_o, gnom);
        end
        repeat (3) @(negedge clk);
        chk(done_o == (gfin == 1) && fail_o == (gfin == 2) && !busy_o,
            {"R9 end flag holds ", tag}, {done_o, fail_o}, gfin);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=0", n_chk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        longint g, c0;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        chk(ctrl_o == CW'(CMIN) && !busy_o && !done_o && !fail_o, "R10 reset outputs", ctrl_o, CMIN);
        chk(!meas_start_o && !meas_stop_o && sens_o == 0 && nom_o == 0, "R10 reset results", sens_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && ctrl_o == CW'(CMIN), "R10 idle after reset", busy_o, 0);

        // directed: the worked slope example scaled, positive slope
        run_cal(16, 1365, 2, 0, 1'b0, "pos slope");
        // negative slope with deviation guard on both signs
        run_cal(-12, 2500, 1, 1, 1'b0, "neg slope dev+");
        run_cal(20, 900, 1, 2, 1'b1, "dev- and busy start");
        // tick guard
        run_cal(-9, 3000, 0, 3, 1'b0, "tick limit");
        // flat oscillator: equal extreme errors
        run_cal(0, 2000, 1, 0, 1'b0, "flat R2");
        // zero point beyond range: clamped trials, no convergence
        run_cal(20, 5000, 0, 0, 1'b0, "out of range R8");
        // zero point near the edges
        run_cal(25, 3, 1, 0, 1'b0, "near bottom");
        run_cal(-25, 4090, 1, 0, 1'b0, "near top");

        for (int k = 0; k < 14; k++) begin
            g = longint'(8 + ($urandom % 18));
            if ($urandom % 2) g = -g;
            c0 = longint'(200 + ($urandom % 3700));
            run_cal(g, c0, int'($urandom % 4), int'($urandom % 3), 1'b0, "random R6");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule